// File: doc/BRIEF.md
# Embedded-Clock Serial Frame Generator

This block turns a stream of 10-bit parallel words into a single serial bit stream that carries its own clock. Every word goes out as a 12-bit frame: a high start bit, the ten data bits with bit 0 first, and a low end bit. The low end bit of one frame is always followed by the high start bit of the next. That gives a rising edge at every frame boundary, and a receiver can recover the word rate from it.

The block runs from one system clock. A bit strobe, `bit_en`, advances the serial output by one bit. The parallel word is sampled on the strobe that begins each frame, and `frame_start` is high while the start bit is on the line. Two sync request inputs, `sync_a` and `sync_b`, replace the data with a training frame of six ones followed by six zeros. The only rising edge in that frame is at the frame boundary. A receiver's lock-lost indication can drive either sync input, so that training frames go out until the receiver locks again.

Top module: `eclk_framer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `bit_en`, `ser_out` and `frame_start` are both 0.
- R2: The first `bit_en` after reset starts a frame. Every frame lasts exactly 12 strobes, and frames follow each other with no gap. `frame_start` is 1 during position 0 of each frame and 0 at positions 1 to 11.
- R3: In a data frame, position 0 (the first bit sent) is 1 and position 11 (the last bit sent) is 0.
- R4: In a data frame, position i+1 carries `word_in[i]` for i = 0..9, so bit 0 is sent first and bit 9 last.
- R5: `word_in` is sampled on the strobe that starts a frame. Changing it later in that frame has no effect on that frame.
- R6: If `sync_a` or `sync_b` is 1 on the strobe that starts a frame, the frame is a sync frame: positions 0 to 5 are 1 and positions 6 to 11 are 0.
- R7: A change of `sync_a` or `sync_b` during a frame has no effect on that frame. It takes effect from the next frame start.
- R8: While a sync request is held over several frames, every frame is a sync frame. The first frame that starts after the request is released is a data frame carrying `word_in`.
- R9: `ser_out` and `frame_start` change only on a clock edge where `bit_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit strobe; each strobe advances the output by one bit |
| word_in | input | 10 | Parallel word, sampled at frame start |
| sync_a | input | 1 | Sync request; 1 selects training frames |
| sync_b | input | 1 | Second sync request, same effect as `sync_a` |
| ser_out | output | 1 | Serial bit stream |
| frame_start | output | 1 | 1 while the first bit of a frame is on `ser_out` |

## Verification
The assertions take three things for granted. `bit_en` is a single-cycle strobe sampled only at rising clock edges. `word_in`, `sync_a` and `sync_b` are settled before the edge that carries the frame-starting strobe. Reset is held for at least one clock edge. The stimulus drives every input on the falling clock edge and gives each strobe at least one idle cycle after it. Mid-frame changes of the word and of the sync requests are always made between strobes, so every frame the checker compares bit by bit started from well-defined inputs.

// File: rtl/eclk_pkg.sv
// Package: shared types for the embedded-clock frame generator.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package eclk_pkg;

    // Kind of frame currently being built
    typedef enum logic {
        FRAME_DATA = 1'b0,
        FRAME_SYNC = 1'b1
    } frame_kind_t;

endpackage

// File: rtl/eclk_frame_builder.sv
// Module: eclk_frame_builder
// Builds the next frame combinationally, in send order (index 0 leaves first).
// A data frame is a high bit, the word LSB first, then a low bit. A sync frame
// is the first half ones and the second half zeros.
// Assumes DATA_W is even, so that the sync halves are equal.
module eclk_frame_builder
    import eclk_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2
) (
    input  logic [DATA_W-1:0]  word,
    input  frame_kind_t        kind,
    output logic [FRAME_W-1:0] frame
);

    localparam int HALF_W = FRAME_W / 2;

    logic [FRAME_W-1:0] data_frame;
    logic [FRAME_W-1:0] sync_frame;

    // Lay out the framing bits, the word bits and the sync pattern bit by bit
    for (genvar g = 0; g < FRAME_W; g++) begin : g_bit
        if (g == 0) begin : g_first
            assign data_frame[g] = 1'b1;
        end else if (g == FRAME_W - 1) begin : g_last
            assign data_frame[g] = 1'b0;
        end else begin : g_payload
            assign data_frame[g] = word[g-1];
        end
        assign sync_frame[g] = (g < HALF_W) ? 1'b1 : 1'b0;
    end

    // Select the frame kind
    always_comb begin
        frame = (kind == FRAME_SYNC) ? sync_frame : data_frame;
    end

endmodule

// File: rtl/eclk_bit_counter.sv
// Module: eclk_bit_counter
// Tracks the bit position inside the frame and decides when a new frame loads.
// The first strobe after reset and the strobe after the last position both load.
// frame_start is registered and marks position 0.
// Assumes bit_en is sampled only at rising clock edges.
module eclk_bit_counter #(
    parameter int FRAME_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic load,
    output logic frame_start
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0] pos;
    logic             running;

    // A load happens on a strobe at the frame boundary or on the first strobe
    always_comb begin
        load = bit_en && (!running || pos == LAST_POS);
    end

    // Advance the position counter and the frame-start marker on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos         <= '0;
            running     <= 1'b0;
            frame_start <= 1'b0;
        end else if (bit_en) begin
            running     <= 1'b1;
            pos         <= load ? '0 : pos + 1'b1;
            frame_start <= load;
        end
    end

endmodule

// File: rtl/eclk_shifter.sv
// Module: eclk_shifter
// Output shift register. On a load it puts the first frame bit on the line and
// keeps the rest. Each later strobe shifts the next bit out.
// Assumes load is only high together with bit_en.
module eclk_shifter #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               ser_out
);

    logic [FRAME_W-2:0] pending;

    // Load a new frame or shift the next pending bit onto the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
            pending <= '0;
        end else if (bit_en) begin
            if (load) begin
                ser_out <= frame[0];
                pending <= frame[FRAME_W-1:1];
            end else begin
                ser_out <= pending[0];
                pending <= {1'b0, pending[FRAME_W-2:1]};
            end
        end
    end

endmodule

// File: rtl/eclk_framer.sv
// Module: eclk_framer (top)
// Embedded-clock serial frame generator. Each word goes out as a high start
// bit, the data LSB first, and a low end bit. While either sync request is high
// at a frame start, a half-ones/half-zeros training frame goes out instead.
// Assumes inputs are synchronous to clk and a word is presented for each frame.
module eclk_framer
    import eclk_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] word_in,
    input  logic              sync_a,
    input  logic              sync_b,
    output logic              ser_out,
    output logic              frame_start
);

    localparam int FRAME_W = DATA_W + 2;

    frame_kind_t        kind;
    logic [FRAME_W-1:0] next_frame;
    logic               load;

    // Either request selects a sync frame; only sampled when a frame loads
    always_comb begin
        kind = (sync_a || sync_b) ? FRAME_SYNC : FRAME_DATA;
    end

    eclk_frame_builder #(
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W)
    ) u_builder (
        .word (word_in),
        .kind (kind),
        .frame(next_frame)
    );

    eclk_bit_counter #(
        .FRAME_W(FRAME_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .load       (load),
        .frame_start(frame_start)
    );

    eclk_shifter #(
        .FRAME_W(FRAME_W)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .load   (load),
        .frame  (next_frame),
        .ser_out(ser_out)
    );

endmodule

// File: rtl/eclk_framer_checker.sv
// Module: eclk_framer_checker
// Property checker bound to eclk_framer. It keeps its own frame position and a
// copy of the inputs sampled at each frame start, and compares the serial
// output against them.
// Assumes bit_en is a strobe sampled at rising clock edges.
module eclk_framer_checker #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic [DATA_W-1:0] word_in,
    input logic              sync_a,
    input logic              sync_b,
    input logic              ser_out,
    input logic              frame_start
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);

    logic [CNT_W-1:0]  c_pos;
    logic              c_seen;
    logic              c_sync;
    logic [DATA_W-1:0] c_word;

    // Observer model: position, and the inputs sampled at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_pos  <= '0;
            c_seen <= 1'b0;
            c_sync <= 1'b0;
            c_word <= '0;
        end else if (bit_en) begin
            c_seen <= 1'b1;
            if (!c_seen || int'(c_pos) == FRAME_W - 1) begin
                c_pos  <= '0;
                c_sync <= sync_a || sync_b;
                c_word <= word_in;
            end else begin
                c_pos <= c_pos + 1'b1;
            end
        end
    end

    // R1: reset drives the line and the marker low
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && !frame_start));

    // R2: the marker is high exactly at position 0
    assert_marker_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_seen |-> (frame_start == (c_pos == '0)));

    // R1: no frame activity before the first strobe
    assert_quiet_before_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !c_seen |-> (!ser_out && !frame_start));

    // R3: start bit high
    assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> ser_out);

    // R3: end bit of a data frame low
    assert_end_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_seen && !c_sync && int'(c_pos) == FRAME_W - 1) |-> !ser_out);

    // R4 R5: payload bits follow the word sampled at frame start, LSB first
    assert_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_seen && !c_sync && c_pos != '0 && int'(c_pos) <= DATA_W)
            |-> (ser_out == c_word[int'(c_pos) - 1]));

    // R6 R7: sync frame shape is half ones then half zeros
    assert_sync_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_seen && c_sync) |-> (ser_out == (int'(c_pos) < FRAME_W / 2)));

    // R9: no change without a strobe
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ser_out) && $stable(frame_start)));

endmodule

bind eclk_framer eclk_framer_checker #(.DATA_W(DATA_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .word_in    (word_in),
    .sync_a     (sync_a),
    .sync_b     (sync_b),
    .ser_out    (ser_out),
    .frame_start(frame_start)
);

// File: tb/test_eclk_framer.sv
// Directed bench for eclk_framer: one task per scenario, each checking itself.
module test_eclk_framer;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 10;
    localparam int FW = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic [DW-1:0] word_in = '0;
    logic          sync_a = 1'b0;
    logic          sync_b = 1'b0;
    logic          ser_out;
    logic          frame_start;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eclk_framer #(.DATA_W(DW)) i_eclk_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .word_in    (word_in),
        .sync_a     (sync_a),
        .sync_b     (sync_b),
        .ser_out    (ser_out),
        .frame_start(frame_start)
    );

    // Record one check and report a failure
    task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                         input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected frames in send order (index 0 leaves first)
    function automatic logic [FW-1:0] exp_data(input logic [DW-1:0] w);
        logic [FW-1:0] f;
        f[0] = 1'b1;
        for (int i = 0; i < DW; i++) f[i+1] = w[i];
        f[FW-1] = 1'b0;
        return f;
    endfunction

    function automatic logic [FW-1:0] exp_sync();
        logic [FW-1:0] f;
        for (int i = 0; i < FW; i++) f[i] = (i < FW/2);
        return f;
    endfunction

    // One strobe, then an idle cycle. Samples the bit after the strobe edge
    // and checks that it holds through the idle cycle (R9).
    task automatic strobe(output logic b, output logic fs);
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        b  = ser_out;
        fs = frame_start;
        @(negedge clk);
        if (ser_out !== b || frame_start !== fs) begin
            errors++;
            checks++;
            $display("FAIL R9 actual=%b%b expected=%b%b", ser_out, frame_start, b, fs);
        end
    endtask

    // Receive one frame. At position chg_at the word and sync inputs change.
    task automatic run_frame(input int chg_at, input logic [DW-1:0] nw,
                             input logic [1:0] ns, output logic [FW-1:0] f,
                             output logic [FW-1:0] marks);
        logic b, fs;
        for (int i = 0; i < FW; i++) begin
            strobe(b, fs);
            f[i] = b;
            marks[i] = fs;
            if (i == chg_at) begin
                word_in = nw;
                {sync_b, sync_a} = ns;
            end
        end
    endtask

    // Scenario: reset state and the idle line before the first strobe (R1)
    task automatic t_reset();
        logic b, fs;
        logic [FW-1:0] f, m;
        rst_n = 1'b0;
        word_in = 10'h3FF;
        repeat (3) begin
            strobe(b, fs);
            check(b === 1'b0 && fs === 1'b0, "R1 reset idle", {b, fs}, '0);
        end
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(ser_out === 1'b0 && frame_start === 1'b0, "R1 idle after release",
              {ser_out, frame_start}, '0);
        run_frame(-1, '0, 2'b00, f, m);
        check(f === exp_data(10'h3FF), "R2 first frame on first strobe", f, exp_data(10'h3FF));
    endtask

    // Scenario: several words, framing bits, bit order, marker (R2 R3 R4)
    task automatic t_data();
        logic [DW-1:0] words [6] = '{10'h000, 10'h3FF, 10'h2AA, 10'h155, 10'h001, 10'h200};
        logic [FW-1:0] f, m;
        foreach (words[k]) begin
            word_in = words[k];
            run_frame(-1, '0, 2'b00, f, m);
            check(f === exp_data(words[k]), "R4 data bit order", f, exp_data(words[k]));
            check(f[0] === 1'b1 && f[FW-1] === 1'b0, "R3 framing bits", f, exp_data(words[k]));
            check(m === {{(FW-1){1'b0}}, 1'b1}, "R2 frame_start at position 0 only",
                  m, {{(FW-1){1'b0}}, 1'b1});
        end
    endtask

    // Scenario: the word changes mid-frame (R5)
    task automatic t_word_mid();
        logic [FW-1:0] f, m;
        word_in = 10'h0F0;
        run_frame(3, 10'h30F, 2'b00, f, m);
        check(f === exp_data(10'h0F0), "R5 mid-frame word ignored", f, exp_data(10'h0F0));
        run_frame(-1, '0, 2'b00, f, m);
        check(f === exp_data(10'h30F), "R5 new word next frame", f, exp_data(10'h30F));
    endtask

    // Scenario: each sync input on its own (R6)
    task automatic t_sync_each();
        logic [FW-1:0] f, m;
        word_in = 10'h155;
        sync_a = 1'b1;
        run_frame(-1, '0, 2'b00, f, m);
        check(f === exp_sync(), "R6 sync_a frame", f, exp_sync());
        sync_a = 1'b0;
        sync_b = 1'b1;
        run_frame(-1, '0, 2'b00, f, m);
        check(f === exp_sync(), "R6 sync_b frame", f, exp_sync());
        sync_b = 1'b0;
        run_frame(-1, '0, 2'b00, f, m);
        check(f === exp_data(10'h155), "R6 data after sync", f, exp_data(10'h155));
    endtask

    // Scenario: sync changes mid-frame take effect at the next frame (R7)
    task automatic t_sync_mid();
        logic [FW-1:0] f, m;
        word_in = 10'h2C3;
        run_frame(5, 10'h2C3, 2'b01, f, m);
        check(f === exp_data(10'h2C3), "R7 raise mid-frame ignored", f, exp_data(10'h2C3));
        run_frame(2, 10'h2C3, 2'b00, f, m);
        check(f === exp_sync(), "R7 sync from next frame; drop ignored", f, exp_sync());
        run_frame(-1, '0, 2'b00, f, m);
        check(f === exp_data(10'h2C3), "R7 drop at next frame", f, exp_data(10'h2C3));
    endtask

    // Scenario: receiver lock feedback drives sync until lock returns (R8)
    task automatic t_lock_loop();
        logic [FW-1:0] f, m;
        logic lock_lost = 1'b1;
        int good = 0;
        word_in = 10'h1A5;
        sync_b = lock_lost;
        for (int n = 0; n < 4 && lock_lost; n++) begin
            run_frame(-1, '0, 2'b00, f, m);
            check(f === exp_sync(), "R8 sync while lock lost", f, exp_sync());
            if (f === exp_sync()) good++;
            if (good >= 3) lock_lost = 1'b0;
            sync_b = lock_lost;
        end
        run_frame(-1, '0, 2'b00, f, m);
        check(f === exp_data(10'h1A5), "R8 data after relock", f, exp_data(10'h1A5));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Scenario sequence
    initial begin
        t_reset();
        t_data();
        t_word_mid();
        t_sync_each();
        t_sync_mid();
        t_lock_loop();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule